// File: doc/BRIEF.md
# Clocked Serial Programming Port (Slave Side)

This block is the device end of a four-wire, clock-synchronous serial link used by an external programmer to move command, address and data bytes into a chip, and read data and status bytes back. The programmer drives the transfer clock. The block samples the receive line on each rising edge of that clock and updates the transmit line on each falling edge. Every byte is eight bits long and travels least significant bit first in both directions.

Inside the chip, a command engine sees a plain byte interface. It gets each received byte with a one-cycle valid strobe. It loads the next byte to send with a load strobe. It reports its own processing work, such as an erase or a program step, through a busy input. A BUSY output to the programmer goes high as soon as a byte starts. It stays high through the byte, through a short hand-over window, and for as long as the engine reports busy. The programmer waits for BUSY to fall before it starts the next byte.

The transfer clock and receive line pass through two-flop synchronisers into the system clock domain. The system clock must run at least four times faster than the transfer clock. The transfer clock idles low.

Top module: `sprog_slave`

## Requirements
- R1: After the eighth rising transfer-clock edge of a byte, `rxByte` holds the eight sampled bits, with the first bit received in bit 0. `rxValid` is high for exactly one system cycle.
- R2: Each received bit is the level of `rxdIn` at the rising transfer-clock edge. Changes on `rxdIn` while the transfer clock is high have no effect.
- R3: Bit 0 of the loaded transmit byte is on `txdOut` before the first rising edge. Bit k appears after the k-th falling edge, so the host sees bits in order 0 to 7 at its rising edges.
- R4: While no byte has been loaded, `txdOut` shifts out all ones (0xFF). Once a byte completes, the transmit register returns to all ones and `txdOut` is high.
- R5: A `txLoad` strobe takes effect only while no byte is in progress (no rising edge yet in the current byte). A load in the middle of a byte is ignored and does not change the bits sent.
- R6: `busyOut` is low when idle with `coreBusy` low. It goes high within three system cycles of the first rising edge of a byte and stays high until the byte completes.
- R7: `busyOut` stays high in the `rxValid` cycle and the cycle after it. After that it follows `coreBusy`.
- R8: A synchronous reset (`rst` high) clears the bit counter and both shift registers. `busyOut` and `rxValid` go low and `txdOut` goes high. A partly received byte is discarded, so the next byte is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclkIn | input | 1 | Transfer clock from the programmer, idle low |
| rxdIn | input | 1 | Serial receive data |
| txdOut | output | 1 | Serial transmit data, push-pull |
| busyOut | output | 1 | High while the port cannot take a new byte |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe when rxByte is updated |
| txByte | input | 8 | Byte to transmit next |
| txLoad | input | 1 | Load strobe for txByte |
| coreBusy | input | 1 | Command engine is processing |

## Verification
A pin change on the transfer clock takes effect three system cycles later: two synchroniser stages plus the edge register. The bench therefore holds each clock phase for six system cycles and samples `txdOut` and `busyOut` only at the end of a phase. After the eighth rising edge, the bench polls `rxValid` on falling system-clock edges. It then checks the byte and that the strobe is gone one cycle later. `busyOut` is checked in the strobe cycle, in the cycle after it, and one cycle after `coreBusy` is released. `txdOut` follows a load within one cycle, so loads are always followed by a full phase of waiting.

// File: rtl/sprog_pkg.sv
`timescale 1ns/1ps
package sprog_pkg;
  // strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic sample;   // rising transfer-clock edge: take one receive bit
    logic capture;  // last bit of a byte: publish received byte
    logic shiftTx;  // falling edge inside a byte: advance transmit bit
    logic loadTx;   // accepted load of a new transmit byte
  } strobe_t;
endpackage

// File: rtl/sprog_ctrl.sv
`timescale 1ns/1ps
module sprog_ctrl
  import sprog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclkIn,
  input  logic    txLoad,
  input  logic    coreBusy,
  output strobe_t strb,
  output logic    xferActive,
  output logic    busyOut
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam int HOLD_CYCLES = 2;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES:0] sclkPipe;
  logic                 sclkSync, sclkPrev, sclkRise, sclkFall;
  logic [CNT_W-1:0]     bitCnt;
  logic [HOLD_W-1:0]    holdCnt;

  // synchroniser stages plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sclkPipe <= '0;
    else     sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
  end

  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign sclkPrev = sclkPipe[SYNC_STAGES];
  assign sclkRise = sclkSync & ~sclkPrev;
  assign sclkFall = ~sclkSync & sclkPrev;

  always_ff @(posedge clk) begin
    if (rst)           bitCnt <= '0;
    else if (sclkRise) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  assign xferActive = (bitCnt != '0);

  always_comb begin
    strb.sample  = sclkRise;
    strb.capture = sclkRise && (bitCnt == LAST_BIT);
    strb.shiftTx = sclkFall && xferActive;
    strb.loadTx  = txLoad && !xferActive && !sclkRise;
  end

  // hand-over window so the engine has time to raise coreBusy
  always_ff @(posedge clk) begin
    if (rst)                  holdCnt <= '0;
    else if (strb.capture)    holdCnt <= HOLD_W'(HOLD_CYCLES);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign busyOut = xferActive || (holdCnt != '0) || coreBusy;
endmodule

// File: rtl/sprog_dpath.sv
`timescale 1ns/1ps
module sprog_dpath
  import sprog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxdIn,
  input  logic [DATA_W-1:0] txByte,
  input  strobe_t           strb,
  output logic              txdOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);
  logic [SYNC_STAGES-1:0] rxdPipe;
  logic                   rxdSync;
  logic [DATA_W-1:0]      rxShift, rxNext, txShift;

  // same depth as the clock path so data and edge line up
  always_ff @(posedge clk) begin
    if (rst) rxdPipe <= '0;
    else     rxdPipe <= {rxdPipe[SYNC_STAGES-2:0], rxdIn};
  end
  assign rxdSync = rxdPipe[SYNC_STAGES-1];

  // first bit in ends up in bit 0
  assign rxNext = {rxdSync, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.capture;
      if (strb.sample)  rxShift <= rxNext;
      if (strb.capture) rxByte  <= rxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               txShift <= '1;
    else if (strb.capture) txShift <= '1;
    else if (strb.loadTx)  txShift <= txByte;
    else if (strb.shiftTx) txShift <= {1'b1, txShift[DATA_W-1:1]};
  end

  assign txdOut = txShift[0];
endmodule

// File: rtl/sprog_slave.sv
`timescale 1ns/1ps
module sprog_slave
  import sprog_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkIn,
  input  logic              rxdIn,
  output logic              txdOut,
  output logic              busyOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txLoad,
  input  logic              coreBusy
);
  strobe_t strb;
  logic    xferActive;

  sprog_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sclkIn     (sclkIn),
    .txLoad     (txLoad),
    .coreBusy   (coreBusy),
    .strb       (strb),
    .xferActive (xferActive),
    .busyOut    (busyOut)
  );

  sprog_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .rxdIn   (rxdIn),
    .txByte  (txByte),
    .strb    (strb),
    .txdOut  (txdOut),
    .rxByte  (rxByte),
    .rxValid (rxValid)
  );
endmodule

// File: rtl/sprog_chk.sv
`timescale 1ns/1ps
module sprog_chk (
  input logic clk,
  input logic rst,
  input logic rxValid,
  input logic busyOut,
  input logic txdOut,
  input logic coreBusy,
  input logic xferActive
);
  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_tx_idle_R4: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> txdOut);

  assert_busy_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    xferActive |-> busyOut);

  assert_busy_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> busyOut);

  assert_busy_after_R7: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> busyOut);

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !coreBusy) |-> (!busyOut && !rxValid && txdOut));
endmodule

bind sprog_slave sprog_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rxValid    (rxValid),
  .busyOut    (busyOut),
  .txdOut     (txdOut),
  .coreBusy   (coreBusy),
  .xferActive (xferActive)
);

// File: tb/test_sprog_slave.sv
`timescale 1ns/1ps
module test_sprog_slave;
  localparam int H = 6;   // system cycles per transfer-clock phase

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclkIn = 1'b0;
  logic       rxdIn = 1'b0;
  logic       txdOut, busyOut, rxValid;
  logic [7:0] rxByte;
  logic [7:0] txByte = 8'h00;
  logic       txLoad = 1'b0;
  logic       coreBusy = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sprog_slave i_sprog_slave (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .rxdIn(rxdIn), .txdOut(txdOut),
    .busyOut(busyOut), .rxByte(rxByte), .rxValid(rxValid), .txByte(txByte),
    .txLoad(txLoad), .coreBusy(coreBusy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic expBit(input logic [7:0] v, input int k);
    return v[k];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadByte(input logic [7:0] v);
    @(negedge clk);
    txByte = v; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  // one full byte; txExp is what the host must see on txdOut
  task automatic sendByte(input logic [7:0] rxv, input logic [7:0] txExp,
                          input bit loadMid, input int holdCycles);
    bit found;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rxdIn = rxv[k];
      waitN(H);
      if (k == 3 && loadMid) begin
        loadByte(~txExp);
        waitN(H);
        chk(txdOut == expBit(txExp, k), "R5 mid-byte load ignored", txdOut, expBit(txExp, k));
      end else begin
        chk(txdOut == expBit(txExp, k), (txExp == 8'hFF) ? "R4 unloaded ones" : "R3 tx bit", txdOut, expBit(txExp, k));
      end
      if (k == 0) chk(busyOut == 1'b0, "R6 idle busy low", busyOut, 0);
      sclkIn = 1'b1;
      if (k < 7) begin
        waitN(H);
        rxdIn = ~rxv[k];   // disturb while clock high (R2)
        waitN(2);
        chk(busyOut == 1'b1, "R6 busy during byte", busyOut, 1);
        sclkIn = 1'b0;
      end else begin
        found = 1'b0;
        for (int c = 0; c < 10 && !found; c++) begin
          @(negedge clk);
          if (rxValid) found = 1'b1;
        end
        chk(found, "R1 valid strobe", found, 1);
        chk(rxByte == rxv, "R1 R2 received byte", rxByte, rxv);
        chk(busyOut == 1'b1, "R7 busy in strobe cycle", busyOut, 1);
        if (holdCycles > 0) begin
          coreBusy = 1'b1;
          for (int c = 0; c < holdCycles; c++) begin
            @(negedge clk);
            if (c == 0) chk(rxValid == 1'b0, "R1 strobe one cycle", rxValid, 0);
            chk(busyOut == 1'b1, "R7 busy follows core", busyOut, 1);
          end
          coreBusy = 1'b0;
          @(negedge clk);
          chk(busyOut == 1'b0, "R7 busy drops with core", busyOut, 0);
        end else begin
          @(negedge clk);
          chk(rxValid == 1'b0, "R1 strobe one cycle", rxValid, 0);
          chk(busyOut == 1'b1, "R7 busy cycle after strobe", busyOut, 1);
          waitN(2);
          chk(busyOut == 1'b0, "R7 busy released", busyOut, 0);
        end
        chk(txdOut == 1'b1, "R4 tx register back to ones", txdOut, 1);
        sclkIn = 1'b0;
        rxdIn  = 1'b0;
        waitN(H);
      end
    end
  endtask

  initial begin
    logic [7:0] rv, tv;
    int unsigned seed;
    seed = $urandom(32'd4242);
    waitN(4);
    chk(busyOut == 1'b0 && rxValid == 1'b0 && txdOut == 1'b1, "R8 reset state",
        {busyOut, rxValid, txdOut}, 3'b001);
    rst = 1'b0;
    waitN(3);

    // directed: unloaded transmit, then loaded, then core hold
    sendByte(8'hA5, 8'hFF, 1'b0, 0);
    loadByte(8'h3C);
    waitN(2);
    sendByte(8'h01, 8'h3C, 1'b0, 4);
    loadByte(8'h80);
    waitN(2);
    sendByte(8'hFE, 8'h80, 1'b1, 0);   // R5 mid-byte load
    sendByte(8'h00, 8'hFF, 1'b0, 2);

    // R8: reset in the middle of a byte
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rxdIn = 1'b1; waitN(H);
      sclkIn = 1'b1; waitN(H);
      sclkIn = 1'b0; waitN(H);
    end
    @(negedge clk); rst = 1'b1;
    waitN(2); rst = 1'b0;
    @(negedge clk);
    chk(busyOut == 1'b0 && txdOut == 1'b1, "R8 mid-byte reset", {busyOut, txdOut}, 2'b01);
    rxdIn = 1'b0;
    waitN(2);
    sendByte(8'h5A, 8'hFF, 1'b0, 0);   // R8: counter cleared, full byte received

    // constrained random
    for (int n = 0; n < 24; n++) begin
      rv = 8'($urandom);
      if ($urandom % 2 == 0) begin
        tv = 8'($urandom);
        loadByte(tv);
        waitN(2);
      end else begin
        tv = 8'hFF;
      end
      sendByte(rv, tv, ($urandom % 4) == 0 && tv != 8'hFF, ($urandom % 3 == 0) ? 3 : 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule